// File: doc/BRIEF.md
# Packed 64-bit Lane Equality Comparator

This unit splits two 512-bit source vectors into eight 64-bit lanes and tests each lane pair for equality. The outcome is written in one of two ways. In a vector form, every lane becomes a field of all ones or all zeros. In a mask form, every lane becomes a single bit. A two-bit mode input selects the output form and how the upper part of the vector result is treated. The upper part can be carried over from an old destination value, cleared, or written over a 256-bit span.

In mask mode a length code sets how many lanes take part: 2, 4 or 8. A per-lane write-mask gates each result bit. A broadcast flag can replace the whole second source with copies of its lowest 64-bit lane. Results are registered when `in_valid` is high and are flagged by `out_valid` one cycle later. The output that the current mode does not write keeps its previous value.

Top module: `qword_eq_unit`

## Requirements
- R1: In vector modes (mode codes 0, 1, 2), each written 64-bit lane of `vec_out` is all ones when the lane of `src_a` equals the same lane of `src_b`, and all zeros otherwise.
- R2: Mode code 0 writes lanes 0 and 1 (bits 127:0) with compare results. Bits 511:128 of `vec_out` take the matching bits of `dest_old`.
- R3: Mode code 1 writes lanes 0 and 1 with compare results and clears bits 511:128 of `vec_out`.
- R4: Mode code 2 writes lanes 0 to 3 (bits 255:0) with compare results and clears bits 511:256.
- R5: Mode code 3 sets `mask_out[i]` to the lane-i equality ANDed with `wmask[i]`, for lanes below the active count. The active count is 2 for `vlen` 0, 4 for `vlen` 1, and 8 for `vlen` 2 or 3. Mask bits at or above the active count are zero.
- R6: When `bcast` is 1 in mode code 3, `src_b[63:0]` is the second operand for every lane. In vector modes `bcast` has no effect.
- R7: `out_valid` equals `in_valid` delayed by one clock. While `in_valid` is 0, neither `vec_out` nor `mask_out` changes.
- R8: An operation in mode code 3 leaves `vec_out` unchanged. An operation in a vector mode leaves `mask_out` unchanged.
- R9: Synchronous active-high `rst` clears `vec_out`, `mask_out` and `out_valid` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request this cycle |
| mode | input | 2 | 0 keep-upper 128, 1 clear-upper 128, 2 vector 256, 3 mask |
| vlen | input | 2 | Mask-mode length: 0 two lanes, 1 four lanes, 2/3 eight lanes |
| bcast | input | 1 | Mask mode: replicate `src_b[63:0]` to all lanes |
| wmask | input | 8 | Mask-mode per-lane write gate |
| dest_old | input | 512 | Prior destination, source of kept upper bits |
| src_a | input | 512 | First operand vector |
| src_b | input | 512 | Second operand vector |
| vec_out | output | 512 | Registered vector result |
| mask_out | output | 8 | Registered mask result |
| out_valid | output | 1 | Result updated in previous cycle |

## Verification
The assertions assume that `mode`, `vlen` and `dest_old` are stable and meaningful whenever `in_valid` is high, and that reset is applied before the first request. The stimulus drives every input on the falling edge and holds it for a full cycle. It raises `in_valid` for one cycle per operation and lowers it in between. Operands are built so that each lane's expected equality is known in advance from a sweep pattern, and unequal lanes differ in exactly one bit. During broadcast, the upper lanes of `src_b` carry values that would invert the result if those lanes were wrongly used.

// File: rtl/qcmp_pkg.sv
package qcmp_pkg;

    localparam int QC_LANE_W      = 64;
    localparam int QC_MAX_LANES   = 8;
    localparam int QC_NARROW      = 2;   // lanes in a 128-bit result
    localparam int QC_MID         = 4;   // lanes in a 256-bit result

    typedef enum logic [1:0] {
        QM_KEEP128 = 2'd0,
        QM_ZERO128 = 2'd1,
        QM_VEC256  = 2'd2,
        QM_MASK    = 2'd3
    } qmode_e;

    typedef enum logic [1:0] {
        QL_128 = 2'd0,
        QL_256 = 2'd1,
        QL_512 = 2'd2,
        QL_ALT = 2'd3
    } qlen_e;

    typedef struct packed {
        qmode_e mode;
        qlen_e  len;
        logic   bcast;
    } qctl_t;

    // number of lanes taking part in a mask-mode compare
    function automatic int unsigned active_lanes(input qlen_e len, input int unsigned total);
        case (len)
            QL_128:  active_lanes = QC_NARROW;
            QL_256:  active_lanes = QC_MID;
            default: active_lanes = total;
        endcase
    endfunction

endpackage

// File: rtl/qcmp_operand_sel.sv
module qcmp_operand_sel
    import qcmp_pkg::*;
#(
    parameter int LANE_W    = QC_LANE_W,
    parameter int NUM_LANES = QC_MAX_LANES,
    localparam int VEC_W    = LANE_W * NUM_LANES
) (
    input  logic [VEC_W-1:0] src_b,
    input  logic             bcast_en,
    output logic [VEC_W-1:0] b_eff
);
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        if (i == 0) begin : g_base
            assign b_eff[LANE_W-1:0] = src_b[LANE_W-1:0];
        end else begin : g_rep
            assign b_eff[i*LANE_W +: LANE_W] = bcast_en ? src_b[LANE_W-1:0]
                                                        : src_b[i*LANE_W +: LANE_W];
        end
    end
endmodule

// File: rtl/qcmp_lane_eq.sv
module qcmp_lane_eq
    import qcmp_pkg::*;
#(
    parameter int LANE_W    = QC_LANE_W,
    parameter int NUM_LANES = QC_MAX_LANES,
    localparam int VEC_W    = LANE_W * NUM_LANES
) (
    input  logic [VEC_W-1:0]     op_a,
    input  logic [VEC_W-1:0]     op_b,
    output logic [NUM_LANES-1:0] lane_eq
);
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_cmp
        assign lane_eq[i] = (op_a[i*LANE_W +: LANE_W] == op_b[i*LANE_W +: LANE_W]);
    end
endmodule

// File: rtl/qcmp_result_merge.sv
module qcmp_result_merge
    import qcmp_pkg::*;
#(
    parameter int LANE_W    = QC_LANE_W,
    parameter int NUM_LANES = QC_MAX_LANES,
    localparam int VEC_W    = LANE_W * NUM_LANES
) (
    input  logic [NUM_LANES-1:0] lane_eq,
    input  qctl_t                ctl,
    input  logic [NUM_LANES-1:0] wmask,
    input  logic [VEC_W-1:0]     dest_old,
    output logic [VEC_W-1:0]     vec_nxt,
    output logic [NUM_LANES-1:0] mask_nxt
);
    int unsigned n_active;
    always_comb n_active = active_lanes(ctl.len, NUM_LANES);

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        logic [LANE_W-1:0] fill;
        logic [LANE_W-1:0] keep;
        assign fill = {LANE_W{lane_eq[i]}};
        assign keep = dest_old[i*LANE_W +: LANE_W];

        always_comb begin
            unique case (ctl.mode)
                QM_KEEP128: vec_nxt[i*LANE_W +: LANE_W] = (i < QC_NARROW) ? fill : keep;
                QM_ZERO128: vec_nxt[i*LANE_W +: LANE_W] = (i < QC_NARROW) ? fill : '0;
                QM_VEC256:  vec_nxt[i*LANE_W +: LANE_W] = (i < QC_MID)    ? fill : '0;
                default:    vec_nxt[i*LANE_W +: LANE_W] = keep;
            endcase
        end

        assign mask_nxt[i] = lane_eq[i] & wmask[i] & (n_active > i);
    end
endmodule

// File: rtl/qword_eq_unit.sv
module qword_eq_unit
    import qcmp_pkg::*;
#(
    parameter int LANE_W    = QC_LANE_W,
    parameter int NUM_LANES = QC_MAX_LANES,
    localparam int VEC_W    = LANE_W * NUM_LANES,
    localparam int LO_W     = LANE_W * QC_NARROW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [1:0]           mode,
    input  logic [1:0]           vlen,
    input  logic                 bcast,
    input  logic [NUM_LANES-1:0] wmask,
    input  logic [VEC_W-1:0]     dest_old,
    input  logic [VEC_W-1:0]     src_a,
    input  logic [VEC_W-1:0]     src_b,
    output logic [VEC_W-1:0]     vec_out,
    output logic [NUM_LANES-1:0] mask_out,
    output logic                 out_valid
);
    qctl_t                ctl;
    logic [VEC_W-1:0]     b_eff;
    logic [NUM_LANES-1:0] lane_eq;
    logic [VEC_W-1:0]     vec_nxt;
    logic [NUM_LANES-1:0] mask_nxt;
    logic                 is_mask;

    assign ctl.mode = qmode_e'(mode);
    assign ctl.len  = qlen_e'(vlen);
    assign ctl.bcast = bcast;
    assign is_mask  = (ctl.mode == QM_MASK);

    qcmp_operand_sel #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_sel (
        .src_b    (src_b),
        .bcast_en (ctl.bcast & is_mask),
        .b_eff    (b_eff)
    );

    qcmp_lane_eq #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_eq (
        .op_a    (src_a),
        .op_b    (b_eff),
        .lane_eq (lane_eq)
    );

    qcmp_result_merge #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_merge (
        .lane_eq  (lane_eq),
        .ctl      (ctl),
        .wmask    (wmask),
        .dest_old (dest_old),
        .vec_nxt  (vec_nxt),
        .mask_nxt (mask_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_out   <= '0;
            mask_out  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                if (is_mask) mask_out <= mask_nxt;
                else         vec_out  <= vec_nxt;
            end
        end
    end

    // R9: reset clears all outputs
    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> (vec_out == '0 && mask_out == '0 && !out_valid));

    // R7: valid lags request by one cycle
    p_valid_lag_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (out_valid == $past(in_valid)));

    // R7: idle cycles hold both results
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(vec_out) && $stable(mask_out)));

    // R8: mask operations do not disturb the vector result
    p_mask_keeps_vec_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == QM_MASK) |=> $stable(vec_out));

    // R8: vector operations do not disturb the mask result
    p_vec_keeps_mask_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode != QM_MASK) |=> $stable(mask_out));

    // R2: upper bits follow the old destination
    p_keep_upper_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == QM_KEEP128) |=> (vec_out[VEC_W-1:LO_W] == $past(dest_old[VEC_W-1:LO_W])));

    // R3: upper bits cleared
    p_zero_upper_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == QM_ZERO128) |=> (vec_out[VEC_W-1:LO_W] == '0));

    // R1: lane 0 is a full fill pattern after any vector operation
    p_lane_fill_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode != QM_MASK) |=> (&vec_out[LANE_W-1:0] || ~|vec_out[LANE_W-1:0]));

    // R5: short length leaves the upper mask bits clear
    p_mask_bound_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == QM_MASK && vlen == QL_128) |=> (mask_out[NUM_LANES-1:QC_NARROW] == '0));

endmodule

// File: tb/sim_qword_eq_unit.sv
`timescale 1ns/1ps
module sim_qword_eq_unit;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [1:0]   mode = 2'd0;
    logic [1:0]   vlen = 2'd0;
    logic         bcast = 1'b0;
    logic [7:0]   wmask = 8'h00;
    logic [511:0] dest_old = '0;
    logic [511:0] src_a = '0;
    logic [511:0] src_b = '0;
    logic [511:0] vec_out;
    logic [7:0]   mask_out;
    logic         out_valid;

    int total = 0;
    int bad = 0;
    int opn = 0;
    logic [511:0] exp_vec = '0;
    logic [7:0]   exp_mask = '0;

    always #10 clk = ~clk;   // 50 MHz

    qword_eq_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .vlen(vlen),
        .bcast(bcast), .wmask(wmask), .dest_old(dest_old), .src_a(src_a),
        .src_b(src_b), .vec_out(vec_out), .mask_out(mask_out), .out_valid(out_valid)
    );

    task automatic chk(input string rq, input logic [511:0] act, input logic [511:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", rq, act, exp);
        end
    endtask

    function automatic logic [63:0] flip(input int i, input int n);
        return 64'h1 << ((i * 9 + n) % 64);
    endfunction

    // one operation: pattern bit i says whether lane i should compare equal
    task automatic run_op(input logic [1:0] md, input logic [7:0] pat, input logic bc,
                          input logic [1:0] ln, input logic [7:0] wm);
        logic [63:0] bv;
        logic [63:0] al;
        int act_n;
        @(negedge clk);
        opn++;
        bv = 64'h9E37_79B9_7F4A_7C15 * 64'(opn + 3);
        for (int i = 0; i < 8; i++) begin
            al = (64'hD1B5_4A32_D192_ED03 * 64'(i + 1)) ^ {32'(opn), 32'(pat)};
            dest_old[i*64 +: 64] = ~al ^ 64'(opn);
            if (bc && md == 2'd3) begin
                al = pat[i] ? bv : (bv ^ flip(i, opn));
                src_a[i*64 +: 64] = al;
                // upper lanes would invert the result if used directly
                src_b[i*64 +: 64] = (i == 0) ? bv : (pat[i] ? (al ^ flip(i, opn)) : al);
            end else begin
                src_a[i*64 +: 64] = al;
                src_b[i*64 +: 64] = pat[i] ? al : (al ^ flip(i, opn));
            end
        end
        mode = md; vlen = ln; bcast = bc; wmask = wm; in_valid = 1'b1;
        // expected values from the requirements
        case (md)
            2'd0: begin
                for (int i = 0; i < 2; i++) exp_vec[i*64 +: 64] = {64{pat[i]}};
                exp_vec[511:128] = dest_old[511:128];
            end
            2'd1: begin
                exp_vec = '0;
                for (int i = 0; i < 2; i++) exp_vec[i*64 +: 64] = {64{pat[i]}};
            end
            2'd2: begin
                exp_vec = '0;
                for (int i = 0; i < 4; i++) exp_vec[i*64 +: 64] = {64{pat[i]}};
            end
            default: begin
                act_n = (ln == 2'd0) ? 2 : (ln == 2'd1) ? 4 : 8;
                for (int i = 0; i < 8; i++) exp_mask[i] = pat[i] & wm[i] & (i < act_n);
            end
        endcase
        @(negedge clk);
        in_valid = 1'b0;
        if (md == 2'd3) begin
            chk(bc ? "R6 bcast mask" : "R5 mask", {504'd0, mask_out}, {504'd0, exp_mask});
            chk("R8 vec held", vec_out, exp_vec);
        end else begin
            case (md)
                2'd0: chk(bc ? "R2/R6 keep128 bcast ignored" : "R2 keep128 R1", vec_out, exp_vec);
                2'd1: chk(bc ? "R3/R6 zero128 bcast ignored" : "R3 zero128 R1", vec_out, exp_vec);
                default: chk(bc ? "R4/R6 vec256 bcast ignored" : "R4 vec256 R1", vec_out, exp_vec);
            endcase
            chk("R8 mask held", {504'd0, mask_out}, {504'd0, exp_mask});
        end
        chk("R7 valid", {511'd0, out_valid}, 512'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 reset vec", vec_out, '0);
        chk("R9 reset mask", {504'd0, mask_out}, '0);
        chk("R9 reset valid", {511'd0, out_valid}, '0);
        @(negedge clk);
        rst = 1'b0;

        // vector modes: every equality pattern, broadcast flag both ways
        for (int md = 0; md < 3; md++)
            for (int p = 0; p < 256; p++)
                for (int bc = 0; bc < 2; bc++)
                    run_op(2'(md), 8'(p), 1'(bc), 2'(p), 8'hFF);

        // mask mode: patterns x broadcast x length x write-mask
        for (int p = 0; p < 256; p++)
            for (int bc = 0; bc < 2; bc++)
                for (int ln = 0; ln < 4; ln++)
                    for (int w = 0; w < 3; w++)
                        run_op(2'd3, 8'(p), 1'(bc), 2'(ln),
                               (w == 0) ? 8'hFF : (w == 1) ? (8'(p) ^ 8'hA5) : 8'h0F);

        // all-equal and none-equal corners
        run_op(2'd2, 8'hFF, 1'b0, 2'd0, 8'hFF);
        run_op(2'd2, 8'h00, 1'b0, 2'd0, 8'hFF);
        run_op(2'd3, 8'hFF, 1'b1, 2'd2, 8'hFF);
        run_op(2'd3, 8'h00, 1'b0, 2'd3, 8'hFF);

        // R7: idle with changing inputs leaves outputs alone
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            mode = 2'(k); src_a = ~src_a; dest_old = ~dest_old; wmask = 8'hFF;
        end
        @(negedge clk);
        chk("R7 idle vec", vec_out, exp_vec);
        chk("R7 idle mask", {504'd0, mask_out}, {504'd0, exp_mask});
        chk("R7 idle valid", {511'd0, out_valid}, '0);

        // R9: reset wins over a request
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1; mode = 2'd1;
        @(negedge clk);
        chk("R9 mid reset vec", vec_out, '0);
        chk("R9 mid reset mask", {504'd0, mask_out}, '0);
        chk("R9 mid reset valid", {511'd0, out_valid}, '0);
        in_valid = 1'b0; rst = 1'b0;
        @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule